// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bit Transmitter

This block sends a single data bit over a shared, open line that both ends may drive. Each bit is a high interval followed by a low interval. The ratio of the two intervals carries the value. A zero is a short high and a long low. A one is a long high and a short low. The short interval lasts one time unit `T` and the long interval lasts `MULT_N` units.

The line is driven high from the first cycle of a bit. After the low interval it is driven high again for one cycle. Then the drive is dropped so that the far end can take the line. A one-cycle completion pulse marks the release.

The time unit `T` comes from one of two sources, chosen by a parameter. It is either a fixed constant or a value taken from an input port at the moment the bit starts. A host that receives bits and frames bytes sits around this block and is not part of it.

Top module: `pwb_tx`

## Requirements
- R1: After reset, `line_oe_o` is 0, `done_o` is 0 and `line_o` is 1.
- R2: When `start_i` is 1 while the block is idle and `bit_i` is 0, the line is driven from the next cycle. It is high for `T` cycles and then low for `MULT_N*T` cycles.
- R3: When a start is taken with `bit_i` equal to 1, the line is high for `MULT_N*T` cycles and then low for `T` cycles.
- R4: In the cycle after the low interval ends, the line is driven high with `line_oe_o` still 1, for exactly one cycle.
- R5: `done_o` is 1 for exactly one cycle. That cycle is the first cycle in which `line_oe_o` is 0 after a bit. `line_oe_o` then stays 0 until the next accepted start.
- R6: A start while a bit is in progress, including the `done_o` cycle, is ignored. The ignored start changes neither the waveform nor the bit value in flight, and it does not launch another bit.
- R7: With `RUNTIME_UNIT` = 0, `T` equals the parameter `FIXED_UNIT` (default 16 cycles), and `unit_cfg_i` has no effect.
- R8: With `RUNTIME_UNIT` = 1, `T` is the value of `unit_cfg_i` in the cycle the start is taken. Changes to `unit_cfg_i` during the bit have no effect on that bit.
- R9: With `RUNTIME_UNIT` = 1, a `unit_cfg_i` value of 0 is treated as a unit of 1 cycle.
- R10: `line_o` is 0 only while `line_oe_o` is 1, so the line is never pulled low while released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to send one bit; taken only when idle |
| bit_i | input | 1 | Value of the bit to send, sampled with the start |
| unit_cfg_i | input | UNIT_W | Run-time time unit in cycles (used when RUNTIME_UNIT = 1) |
| line_o | output | 1 | Value driven onto the line |
| line_oe_o | output | 1 | Drive enable for the line; 0 means released |
| done_o | output | 1 | One-cycle pulse when the line is released after a bit |

## Verification
Some properties are checked on every cycle:
- The line never goes low while released.
- The completion pulse always coincides with the enable falling.
- A rising line under drive is always followed by release.
- The latched bit value and the latched run-time unit stay fixed for the whole bit.
- The cycle counter never reaches the unit length.

The exact interval lengths are shown only by the bench's scenarios, which count cycles against `T` and `MULT_N`. The same holds for the choice between the fixed and run-time units, for the zero-unit clamp, and for starts that are ignored while a bit is in flight.

// File: rtl/pwb_tx_pkg.sv
package pwb_tx_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // bit phases, in the order they occur on the line
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_HIGH   = 3'd1,
      PH_LOW    = 3'd2,
      PH_REHIGH = 3'd3,
      PH_DONE   = 3'd4
   } phase_e;

   function automatic logic phase_drives(input phase_e ph);
      return (ph == PH_HIGH) || (ph == PH_LOW) || (ph == PH_REHIGH);
   endfunction

endpackage

// File: rtl/pwb_unit_src.sv
module pwb_unit_src #(
   parameter int unsigned UNIT_W       = 8,
   parameter int unsigned FIXED_UNIT   = 16,
   parameter bit          RUNTIME_UNIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              busy,
   input  logic [UNIT_W-1:0] unit_cfg,
   output logic [UNIT_W-1:0] unit_len
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [UNIT_W-1:0] FIXED_LEN = UNIT_W'(FIXED_UNIT);
   localparam logic [UNIT_W-1:0] ONE       = UNIT_W'(1);

   generate
      if (RUNTIME_UNIT) begin : g_runtime
         logic [UNIT_W-1:0] unit_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               unit_q <= ONE;
            end else if (load) begin
               unit_q <= (unit_cfg == '0) ? ONE : unit_cfg;
            end
         end

         assign unit_len = unit_q;

         // R8: the unit taken at start stays fixed for the whole bit
         assert_unit_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(busy) && busy) |-> $stable(unit_q));

         // R9: a zero unit never reaches the timer
         assert_unit_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
            unit_q != '0);
      end else begin : g_fixed
         logic unused_src;
         assign unused_src = ^{unit_cfg, load, busy, clk, rst_n};
         assign unit_len   = FIXED_LEN;
      end
   endgenerate

endmodule

// File: rtl/pwb_unit_timer.sv
module pwb_unit_timer #(
   parameter int unsigned UNIT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              run,
   input  logic [UNIT_W-1:0] unit_len,
   output logic              tick
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [UNIT_W-1:0] cyc_q;
   logic [UNIT_W-1:0] last_cyc;

   assign last_cyc = unit_len - UNIT_W'(1);
   assign tick     = run && (cyc_q == last_cyc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_q <= '0;
      end else if (restart) begin
         cyc_q <= '0;
      end else if (run) begin
         cyc_q <= tick ? '0 : cyc_q + UNIT_W'(1);
      end
   end

   // R2: the cycle counter stays inside one unit while running
   assert_cyc_in_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cyc_q < unit_len));

endmodule

// File: rtl/pwb_phase_seq.sv
module pwb_phase_seq
   import pwb_tx_pkg::*;
#(
   parameter int unsigned MULT_N = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   bit_in,
   input  logic   tick,
   output logic   accept,
   output phase_e phase
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned     MW     = $clog2(MULT_N + 1);
   localparam logic [MW-1:0]   LONG_L = MW'(MULT_N - 1);

   phase_e        phase_q;
   logic          bit_q;
   logic [MW-1:0] units_q;
   logic [MW-1:0] high_last;
   logic [MW-1:0] low_last;

   assign accept    = start && (phase_q == PH_IDLE);
   assign high_last = bit_q ? LONG_L : '0;
   assign low_last  = bit_q ? '0 : LONG_L;
   assign phase     = phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         bit_q   <= 1'b0;
         units_q <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  phase_q <= PH_HIGH;
                  bit_q   <= bit_in;
                  units_q <= '0;
               end
            end
            PH_HIGH: begin
               if (tick) begin
                  if (units_q == high_last) begin
                     phase_q <= PH_LOW;
                     units_q <= '0;
                  end else begin
                     units_q <= units_q + MW'(1);
                  end
               end
            end
            PH_LOW: begin
               if (tick) begin
                  if (units_q == low_last) begin
                     phase_q <= PH_REHIGH;
                     units_q <= '0;
                  end else begin
                     units_q <= units_q + MW'(1);
                  end
               end
            end
            PH_REHIGH: phase_q <= PH_DONE;
            PH_DONE:   phase_q <= PH_IDLE;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   // R6: the bit value in flight cannot be replaced by a later start
   assert_bit_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(phase_q) != PH_IDLE) |-> $stable(bit_q));

   // R2 / R3: unit count never passes the long interval
   assert_units_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      units_q <= LONG_L);

endmodule

// File: rtl/pwb_tx.sv
module pwb_tx
   import pwb_tx_pkg::*;
#(
   parameter int unsigned UNIT_W       = 8,
   parameter int unsigned MULT_N       = 4,
   parameter int unsigned FIXED_UNIT   = 16,
   parameter bit          RUNTIME_UNIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              bit_i,
   input  logic [UNIT_W-1:0] unit_cfg_i,
   output logic              line_o,
   output logic              line_oe_o,
   output logic              done_o
);
   timeunit 1ns;
   timeprecision 1ps;

   generate
      if (MULT_N < 2) begin : g_bad_mult
         $error("pwb_tx: MULT_N must be at least 2");
      end
      if (FIXED_UNIT < 1) begin : g_bad_unit
         $error("pwb_tx: FIXED_UNIT must be at least 1");
      end
      if (FIXED_UNIT >= (64'd1 << UNIT_W)) begin : g_unit_wide
         $error("pwb_tx: FIXED_UNIT does not fit in UNIT_W bits");
      end
   endgenerate

   phase_e            phase;
   logic              accept;
   logic              tick;
   logic              run;
   logic              busy;
   logic [UNIT_W-1:0] unit_len;

   assign run  = (phase == PH_HIGH) || (phase == PH_LOW);
   assign busy = (phase != PH_IDLE);

   pwb_unit_src #(
      .UNIT_W       (UNIT_W),
      .FIXED_UNIT   (FIXED_UNIT),
      .RUNTIME_UNIT (RUNTIME_UNIT)
   ) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .busy     (busy),
      .unit_cfg (unit_cfg_i),
      .unit_len (unit_len)
   );

   pwb_unit_timer #(
      .UNIT_W (UNIT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (accept),
      .run      (run),
      .unit_len (unit_len),
      .tick     (tick)
   );

   pwb_phase_seq #(
      .MULT_N (MULT_N)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_i),
      .bit_in (bit_i),
      .tick   (tick),
      .accept (accept),
      .phase  (phase)
   );

   assign line_oe_o = phase_drives(phase);
   assign line_o    = (phase != PH_LOW);
   assign done_o    = (phase == PH_DONE);

   // R10: never pull the line low while released
   assert_low_needs_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !line_o |-> line_oe_o);

   // R5: completion coincides with the enable falling
   assert_done_on_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!line_oe_o && $past(line_oe_o)));

   // R4: a driven rise of the line is the last driven cycle, then completion
   assert_rehigh_then_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_oe_o && $rose(line_o)) |=> (done_o && !line_oe_o));

endmodule

// File: tb/pwb_tx_bench.sv
module pwb_tx_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int MULT_N = 4;
   localparam int FIXED_T = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       st0 = 1'b0, b0 = 1'b0, st1 = 1'b0, b1 = 1'b0;
   logic [7:0] cfg0 = 8'd5, cfg1 = 8'd3;
   logic       line0, oe0, done0, line1, oe1, done1;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   pwb_tx u_pwb_tx (
      .clk(clk), .rst_n(rst_n), .start_i(st0), .bit_i(b0), .unit_cfg_i(cfg0),
      .line_o(line0), .line_oe_o(oe0), .done_o(done0)
   );

   pwb_tx #(.RUNTIME_UNIT(1'b1)) u_pwb_tx_rt (
      .clk(clk), .rst_n(rst_n), .start_i(st1), .bit_i(b1), .unit_cfg_i(cfg1),
      .line_o(line1), .line_oe_o(oe1), .done_o(done1)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000) begin
         errors = errors + 1;
         $display("FAIL watchdog (R1..R10 incomplete): actual cycles %0d expected < 50000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic set_start(input int sel, input logic s, input logic v);
      if (sel == 0) begin st0 = s; b0 = v; end
      else          begin st1 = s; b1 = v; end
   endtask

   // sends one bit and compares every cycle with the expected waveform
   task automatic run_bit(input int sel, input logic b, input int t,
                          input int inj_start, input int inj_cfg,
                          input logic [7:0] new_cfg, input string tag);
      int hi = b ? MULT_N : 1;
      int lo = b ? 1 : MULT_N;
      int total = (hi + lo) * t + 1;
      int bad_at = -1;
      logic [2:0] act_v = '0, exp_v = '0;
      @(negedge clk);
      set_start(sel, 1'b1, b);
      @(negedge clk);
      for (int i = 0; i <= total + 4; i++) begin
         logic e_oe, e_line, e_done;
         logic [2:0] a;
         e_oe   = (i < total);
         e_line = !((i >= hi * t) && (i < (hi + lo) * t));
         e_done = (i == total);
         a = (sel == 0) ? {oe0, line0, done0} : {oe1, line1, done1};
         if (bad_at < 0 && a !== {e_oe, e_line, e_done}) begin
            bad_at = i; act_v = a; exp_v = {e_oe, e_line, e_done};
         end
         if (i == inj_start) set_start(sel, 1'b1, ~b);
         else                set_start(sel, 1'b0, b);
         if (i == inj_cfg) cfg1 = new_cfg;
         @(negedge clk);
      end
      checks = checks + 1;
      if (bad_at >= 0) begin
         errors = errors + 1;
         $display("FAIL %s: cycle %0d oe/line/done actual %b expected %b",
                  tag, bad_at, act_v, exp_v);
      end
   endtask

   task automatic test_reset();
      // R1
      chk("R1 fixed oe", oe0, 1'b0);
      chk("R1 fixed done", done0, 1'b0);
      chk("R1 fixed line", line0, 1'b1);
      chk("R1 runtime oe", oe1, 1'b0);
      chk("R1 runtime done", done1, 1'b0);
      chk("R1 runtime line", line1, 1'b1);
   endtask

   task automatic test_fixed_bits();
      cfg0 = 8'd5; // R7: ignored, unit stays FIXED_T
      run_bit(0, 1'b0, FIXED_T, -1, -1, 8'd0, "R2 R4 R5 R7 R10 fixed zero");
      cfg0 = 8'd200;
      run_bit(0, 1'b1, FIXED_T, -1, -1, 8'd0, "R3 R4 R5 R7 fixed one");
   endtask

   task automatic test_busy_start();
      run_bit(0, 1'b1, FIXED_T, 20, -1, 8'd0, "R6 start mid-bit");
      run_bit(0, 1'b0, FIXED_T, (1 + MULT_N) * FIXED_T + 1, -1, 8'd0,
              "R6 start in done cycle");
   endtask

   task automatic test_runtime_unit();
      cfg1 = 8'd3;
      run_bit(1, 1'b1, 3, -1, 2, 8'd9, "R8 runtime unit, change mid-bit");
      run_bit(1, 1'b0, 9, -1, -1, 8'd0, "R8 runtime unit 9");
   endtask

   task automatic test_zero_unit();
      cfg1 = 8'd0;
      run_bit(1, 1'b0, 1, -1, -1, 8'd0, "R9 zero unit, bit 0");
      run_bit(1, 1'b1, 1, -1, -1, 8'd0, "R9 zero unit, bit 1");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_fixed_bits();
      test_busy_start();
      test_runtime_unit();
      test_zero_unit();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule